// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a synchronous RAM with one write port and one read port, each on its own clock and reset. The two ports see the same storage at different word widths. The widths differ by a power of two, and width times depth is the same number of bits on both sides. Storage is held at the narrower of the two widths. A wide access covers a run of consecutive narrow entries. Its least significant slice sits at the lowest narrow address of that run.

All inputs are registered on their own clock. A write lands in the array on the edge after its inputs are captured. A read returns data one read-clock edge after the read address has been captured. An optional output register adds one more edge. While read enable is low, the output keeps its last value.

The read-side clear has two effects. It zeroes the output at once, and it forces the registered read enable high, so the first edge after the clear releases performs a read. A read and a write that meet on the same storage in the same cycle return either the old contents or an unknown value. A parameter picks which.

Top module: `mixw_sdp_ram`

## Requirements
- R1: Narrow address = {wide address, sub-word index}, with the index in the low log2(ratio) bits. Slice i of a wide word (bits i*N+N-1 down to i*N, where N is the narrow width) maps to sub-word index i. With an 8-bit write and a 2-bit read, writing 8'h01 at address 0 reads back 1, 0, 0, 0 at narrow addresses 0 to 3.
- R2: A wide write changes exactly its ratio-many narrow entries, up to and including the last address of the array. The neighbouring entries keep their contents.
- R3: A narrow write changes only its own slice of the wide word that a wide read returns. The other slices keep their contents.
- R4: Read address and read enable are captured on a rising read-clock edge. The addressed data appears on the read output after the next edge. With the output register enabled, it appears one edge later still.
- R5: While the captured read enable is low, the read output holds its value. A changing read address and writes to the shown location do not affect it.
- R6: While the read clear (rrst, active high, asynchronous) is asserted, the captured read enable is 1 and the captured read address is 0. On the first edge after the clear is released, the output shows the data at address 0 even if ren is low.
- R7: While the write clear (wrst, active high, asynchronous) is asserted, the captured write enable is 0. A write presented during the clear does not change the array.
- R8: A read and a write that reach the same storage in the same cycle, on a shared clock, return the old stored data when RDW_MODE is RDW_OLD. They return an unknown value when RDW_MODE is RDW_UNKNOWN. The new data is visible to the next read.
- R9: While the read clear is asserted, the read output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Write-side asynchronous clear, active high |
| wen | input | 1 | Write enable |
| waddr | input | WAW | Write address in write-width words |
| wdata | input | WR_W | Write data |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Read-side asynchronous clear, active high |
| ren | input | 1 | Read enable |
| raddr | input | RAW | Read address in read-width words |
| rdata | output | RD_W | Read data |

## Verification
A write and a read can both reach the same storage in one cycle. The bench provokes this on a shared clock. It presents a write of new data and a narrow read inside that wide word on the same falling edge, so both are captured on the same rising edge. The read result must equal the previously stored value. An immediate re-read must then return the new value. A second pairing is a read clear that lands while read enable is held low: the output must drop to zero, then show address 0 after release, then hold.

// File: rtl/mixw_pkg.sv
`timescale 1ns/1ps
package mixw_pkg;

    // Result of a read that meets a write on the same storage in one cycle
    typedef enum logic {
        RDW_UNKNOWN = 1'b0,
        RDW_OLD     = 1'b1
    } rdw_e;

    function automatic int unsigned min_w(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/mixw_wr_stage.sv
`timescale 1ns/1ps
module mixw_wr_stage #(
    parameter int unsigned WR_W = 8,
    parameter int unsigned WAW  = 6
) (
    input  logic            wclk,
    input  logic            wrst,
    input  logic            wen,
    input  logic [WAW-1:0]  waddr,
    input  logic [WR_W-1:0] wdata,
    output logic            wen_q,
    output logic [WAW-1:0]  waddr_q,
    output logic [WR_W-1:0] wdata_q
);

    typedef struct packed {
        logic            en;
        logic [WAW-1:0]  addr;
        logic [WR_W-1:0] data;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en   = wen;
        st_d.addr = waddr;
        st_d.data = wdata;
    end

    always_ff @(posedge wclk or posedge wrst) begin
        if (wrst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign wen_q   = st_q.en;
    assign waddr_q = st_q.addr;
    assign wdata_q = st_q.data;

endmodule

// File: rtl/mixw_store.sv
`timescale 1ns/1ps
module mixw_store #(
    parameter int unsigned NW     = 2,
    parameter int unsigned NDEPTH = 256,
    parameter int unsigned NAW    = 8,
    parameter int unsigned WR_W   = 8,
    parameter int unsigned RD_W   = 2
) (
    input  logic            wclk,
    input  logic            wen_q,
    input  logic [NAW-1:0]  wbase,
    input  logic [WR_W-1:0] wdata_q,
    input  logic [NAW-1:0]  rbase,
    output logic [RD_W-1:0] rword
);

    localparam int unsigned WR_RATIO = WR_W / NW;
    localparam int unsigned RD_RATIO = RD_W / NW;

    logic [NW-1:0] mem [NDEPTH];

    // slice i of the wide write lands at narrow entry base + i
    always_ff @(posedge wclk) begin
        if (wen_q) begin
            for (int i = 0; i < WR_RATIO; i++) begin
                mem[wbase + NAW'(i)] <= wdata_q[i*NW +: NW];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < RD_RATIO; i++) begin
            rword[i*NW +: NW] = mem[rbase + NAW'(i)];
        end
    end

endmodule

// File: rtl/mixw_rd_stage.sv
`timescale 1ns/1ps
module mixw_rd_stage
    import mixw_pkg::*;
#(
    parameter int unsigned RD_W     = 2,
    parameter int unsigned RAW      = 8,
    parameter bit          OUT_REG  = 1'b0,
    parameter rdw_e        RDW_MODE = RDW_OLD
) (
    input  logic            rclk,
    input  logic            rrst,
    input  logic            ren,
    input  logic [RAW-1:0]  raddr,
    input  logic [RD_W-1:0] rword,
    input  logic            collide,
    output logic [RAW-1:0]  raddr_q,
    output logic            ren_q,
    output logic [RD_W-1:0] rdata
);

    typedef struct packed {
        logic            en;
        logic [RAW-1:0]  addr;
        logic [RD_W-1:0] word;
        logic [RD_W-1:0] outw;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en   = ren;
        st_d.addr = raddr;
        if (st_q.en) begin
            if (collide && (RDW_MODE == RDW_UNKNOWN)) st_d.word = 'x;
            else                                      st_d.word = rword;
        end
        st_d.outw = st_q.word;
    end

    // clear: outputs to zero, captured enable forced high
    always_ff @(posedge rclk or posedge rrst) begin
        if (rrst) st_q <= '{en: 1'b1, default: '0};
        else      st_q <= st_d;
    end

    assign raddr_q = st_q.addr;
    assign ren_q   = st_q.en;

    generate
        if (OUT_REG) begin : g_oreg
            assign rdata = st_q.outw;
        end else begin : g_flow
            assign rdata = st_q.word;
        end
    endgenerate

endmodule

// File: rtl/mixw_sdp_ram.sv
`timescale 1ns/1ps
module mixw_sdp_ram
    import mixw_pkg::*;
#(
    parameter int unsigned WR_W       = 8,
    parameter int unsigned RD_W       = 2,
    parameter int unsigned TOTAL_BITS = 512,
    parameter bit          OUT_REG    = 1'b0,
    parameter rdw_e        RDW_MODE   = RDW_OLD,
    localparam int unsigned WAW = $clog2(TOTAL_BITS / WR_W),
    localparam int unsigned RAW = $clog2(TOTAL_BITS / RD_W)
) (
    input  logic            wclk,
    input  logic            wrst,
    input  logic            wen,
    input  logic [WAW-1:0]  waddr,
    input  logic [WR_W-1:0] wdata,
    input  logic            rclk,
    input  logic            rrst,
    input  logic            ren,
    input  logic [RAW-1:0]  raddr,
    output logic [RD_W-1:0] rdata
);

    localparam int unsigned NW     = min_w(WR_W, RD_W);
    localparam int unsigned NDEPTH = TOTAL_BITS / NW;
    localparam int unsigned NAW    = $clog2(NDEPTH);
    localparam int unsigned WLOG   = $clog2(WR_W / NW);
    localparam int unsigned RLOG   = $clog2(RD_W / NW);
    localparam int unsigned MLOG   = WLOG + RLOG;

    logic            wen_q;
    logic [WAW-1:0]  waddr_q;
    logic [WR_W-1:0] wdata_q;
    logic [RAW-1:0]  raddr_q;
    logic            ren_q;
    logic [RD_W-1:0] rword;
    logic [NAW-1:0]  wbase, rbase;
    logic            collide;

    // narrow-entry bases: wide address shifted up, sub-word index in low bits
    always_comb begin
        wbase   = NAW'(waddr_q) << WLOG;
        rbase   = NAW'(raddr_q) << RLOG;
        collide = wen_q && ((wbase >> MLOG) == (rbase >> MLOG));
    end

    mixw_wr_stage #(.WR_W(WR_W), .WAW(WAW)) u_wr (
        .wclk(wclk), .wrst(wrst), .wen(wen), .waddr(waddr), .wdata(wdata),
        .wen_q(wen_q), .waddr_q(waddr_q), .wdata_q(wdata_q)
    );

    mixw_store #(.NW(NW), .NDEPTH(NDEPTH), .NAW(NAW), .WR_W(WR_W), .RD_W(RD_W)) u_mem (
        .wclk(wclk), .wen_q(wen_q), .wbase(wbase), .wdata_q(wdata_q),
        .rbase(rbase), .rword(rword)
    );

    mixw_rd_stage #(.RD_W(RD_W), .RAW(RAW), .OUT_REG(OUT_REG), .RDW_MODE(RDW_MODE)) u_rd (
        .rclk(rclk), .rrst(rrst), .ren(ren), .raddr(raddr), .rword(rword),
        .collide(collide), .raddr_q(raddr_q), .ren_q(ren_q), .rdata(rdata)
    );

endmodule

// File: rtl/mixw_sdp_ram_chk.sv
`timescale 1ns/1ps
module mixw_sdp_ram_chk #(
    parameter int unsigned RD_W    = 2,
    parameter bit          OUT_REG = 1'b0
) (
    input logic            rclk,
    input logic            rrst,
    input logic            wclk,
    input logic            wrst,
    input logic            ren,
    input logic            ren_q,
    input logic            wen_q,
    input logic [RD_W-1:0] rdata
);

    // R9
    out_clear_chk: assert property (@(posedge rclk) rrst |-> (rdata == '0));

    // R6
    ren_forced_chk: assert property (@(posedge rclk) rrst |-> ren_q);

    // R7
    wen_clear_chk: assert property (@(posedge wclk) wrst |-> !wen_q);

    generate
        if (OUT_REG) begin : g_hold_oreg
            // R5
            hold_oreg_chk: assert property (@(posedge rclk) disable iff (rrst)
                !ren |-> ##3 $stable(rdata));
        end else begin : g_hold_flow
            // R5
            hold_flow_chk: assert property (@(posedge rclk) disable iff (rrst)
                !ren |-> ##2 $stable(rdata));
        end
    endgenerate

endmodule

bind mixw_sdp_ram mixw_sdp_ram_chk #(.RD_W(RD_W), .OUT_REG(OUT_REG)) u_chk (
    .rclk(rclk), .rrst(rrst), .wclk(wclk), .wrst(wrst),
    .ren(ren), .ren_q(ren_q), .wen_q(wen_q), .rdata(rdata)
);

// File: tb/sim_mixw_sdp_ram.sv
`timescale 1ns/1ps
module sim_mixw_sdp_ram;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic wrst, rrst;
    logic        w0en, r0en;
    logic [5:0]  w0addr;
    logic [7:0]  w0data;
    logic [7:0]  r0addr;
    logic [1:0]  r0data;
    logic        w1en, r1en;
    logic [6:0]  w1addr;
    logic [3:0]  w1data;
    logic [4:0]  r1addr;
    logic [15:0] r1data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // wide write 8 / narrow read 2, flow-through, old data on collision
    mixw_sdp_ram #(.WR_W(8), .RD_W(2), .TOTAL_BITS(512), .OUT_REG(1'b0)) u0 (
        .wclk(clk), .wrst(wrst), .wen(w0en), .waddr(w0addr), .wdata(w0data),
        .rclk(clk), .rrst(rrst), .ren(r0en), .raddr(r0addr), .rdata(r0data)
    );

    // narrow write 4 / wide read 16, output register
    mixw_sdp_ram #(.WR_W(4), .RD_W(16), .TOTAL_BITS(512), .OUT_REG(1'b1)) u1 (
        .wclk(clk), .wrst(wrst), .wen(w1en), .waddr(w1addr), .wdata(w1data),
        .rclk(clk), .rrst(rrst), .ren(r1en), .raddr(r1addr), .rdata(r1data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr0(input logic [5:0] a, input logic [7:0] d);
        w0en = 1'b1; w0addr = a; w0data = d;
        @(negedge clk);
        w0en = 1'b0;
    endtask

    task automatic rd0(input logic [7:0] a, input logic [1:0] exp, input string req);
        r0en = 1'b1; r0addr = a;
        @(negedge clk);
        r0en = 1'b0;
        @(negedge clk);
        chk(req, 32'(r0data), 32'(exp));
    endtask

    task automatic wr1(input logic [6:0] a, input logic [3:0] d);
        w1en = 1'b1; w1addr = a; w1data = d;
        @(negedge clk);
        w1en = 1'b0;
    endtask

    task automatic rd1(input logic [4:0] a, input logic [15:0] exp, input string req);
        r1en = 1'b1; r1addr = a;
        @(negedge clk);
        r1en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(req, 32'(r1data), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R9 u0 reset", 32'(r0data), 32'h0);
        chk("R9 u1 reset", 32'(r1data), 32'h0);
    endtask

    task automatic t_order();
        wr0(6'd0, 8'h01);
        rd0(8'd0, 2'd1, "R1 addr0");
        rd0(8'd1, 2'd0, "R1 addr1");
        rd0(8'd2, 2'd0, "R1 addr2");
        rd0(8'd3, 2'd0, "R1 addr3");
        wr0(6'd5, 8'hE4);
        rd0(8'd20, 2'd0, "R1 e4 s0");
        rd0(8'd21, 2'd1, "R1 e4 s1");
        rd0(8'd22, 2'd2, "R1 e4 s2");
        rd0(8'd23, 2'd3, "R1 e4 s3");
    endtask

    task automatic t_top_edge();
        wr0(6'd62, 8'hFF);
        wr0(6'd63, 8'h9C);
        rd0(8'd252, 2'd0, "R2 top s0");
        rd0(8'd253, 2'd3, "R2 top s1");
        rd0(8'd254, 2'd1, "R2 top s2");
        rd0(8'd255, 2'd2, "R2 top s3");
        rd0(8'd251, 2'd3, "R2 neighbour kept");
    endtask

    task automatic t_narrow_into_wide();
        wr1(7'd8, 4'h1);
        wr1(7'd9, 4'h2);
        wr1(7'd10, 4'h3);
        wr1(7'd11, 4'h4);
        rd1(5'd2, 16'h4321, "R3 assembled");
        wr1(7'd9, 4'hF);
        rd1(5'd2, 16'h43F1, "R3 one slice");
    endtask

    task automatic t_latency();
        wr0(6'd2, 8'hC6);
        rd0(8'd8, 2'd2, "R4 u0 prior");
        r0en = 1'b1; r0addr = 8'd11;
        @(negedge clk);
        r0en = 1'b0;
        chk("R4 u0 not yet", 32'(r0data), 32'h2);
        @(negedge clk);
        chk("R4 u0 arrives", 32'(r0data), 32'h3);
        wr1(7'd12, 4'h5);
        wr1(7'd13, 4'hA);
        wr1(7'd14, 4'h0);
        wr1(7'd15, 4'hC);
        r1en = 1'b1; r1addr = 5'd3;
        @(negedge clk);
        r1en = 1'b0;
        @(negedge clk);
        chk("R4 u1 not yet", 32'(r1data), 32'h43F1);
        @(negedge clk);
        chk("R4 u1 arrives", 32'(r1data), 32'hC0A5);
    endtask

    task automatic t_hold();
        rd0(8'd9, 2'd1, "R5 setup");
        for (int i = 0; i < 4; i++) begin
            r0addr = 8'(8 + i);
            if (i == 0) begin
                w0en = 1'b1; w0addr = 6'd2; w0data = 8'h00;
            end else begin
                w0en = 1'b0;
            end
            @(negedge clk);
            chk("R5 held", 32'(r0data), 32'h1);
        end
        rd0(8'd9, 2'd0, "R5 write landed");
    endtask

    task automatic t_wr_clear();
        wr0(6'd3, 8'h55);
        @(negedge clk);
        wrst = 1'b1;
        w0en = 1'b1; w0addr = 6'd3; w0data = 8'hAA;
        @(negedge clk);
        @(negedge clk);
        w0en = 1'b0;
        @(negedge clk);
        wrst = 1'b0;
        rd0(8'd12, 2'd1, "R7 lo kept");
        rd0(8'd15, 2'd1, "R7 hi kept");
    endtask

    task automatic t_rd_clear();
        wr0(6'd0, 8'h03);
        @(negedge clk);
        r0en = 1'b0; r0addr = 8'd7;
        rrst = 1'b1;
        @(negedge clk);
        chk("R9 clear zero", 32'(r0data), 32'h0);
        rrst = 1'b0;
        @(negedge clk);
        chk("R6 forced read", 32'(r0data), 32'h3);
        @(negedge clk);
        chk("R6 then hold", 32'(r0data), 32'h3);
    endtask

    task automatic t_collide();
        wr0(6'd10, 8'hFF);
        w0en = 1'b1; w0addr = 6'd10; w0data = 8'h00;
        r0en = 1'b1; r0addr = 8'd41;
        @(negedge clk);
        w0en = 1'b0; r0en = 1'b0;
        @(negedge clk);
        chk("R8 old data", 32'(r0data), 32'h3);
        rd0(8'd41, 2'd0, "R8 new after");
    endtask

    initial begin
        wrst = 1'b1; rrst = 1'b1;
        w0en = 1'b0; w0addr = '0; w0data = '0; r0en = 1'b0; r0addr = '0;
        w1en = 1'b0; w1addr = '0; w1data = '0; r1en = 1'b0; r1addr = '0;
        repeat (3) @(negedge clk);
        t_reset();
        wrst = 1'b0; rrst = 1'b0;
        @(negedge clk);
        t_order();
        t_top_edge();
        t_narrow_into_wide();
        t_latency();
        t_hold();
        t_wr_clear();
        t_rd_clear();
        t_collide();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule